// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block is the bus-facing half of a 16-bit processor front end. It keeps a code segment and an instruction offset, forms the 20-bit physical fetch address from them, and requests 16-bit words from a simple memory port using a request/ready handshake. The two bytes of each returned word are written into a six-entry byte queue, and the decode side draws bytes from it one per cycle. Fetching and draining run at the same time, so the queue keeps filling while earlier bytes are used.

A taken branch drives the flush input together with a new segment and offset. The queue empties at once, and later fetches start from the new target. If a word request is already on the memory port when the flush arrives, the request runs to completion with its original address, and the returned word is dropped. After reset the segment is all ones and the offset is zero, so the first word is read from the top 16 bytes of the address space.

Top module: `fetch_queue_unit`

## Requirements
- R1: While reset is high, `empty_o` is 1 and `mem_req_o` is 0. The first request after reset uses address 20'hFFFF0 (segment 16'hFFFF, offset 0).
- R2: A request address equals the segment times 16 plus the offset, truncated to 20 bits. For example, segment FFFF with offset 0020 gives 00010.
- R3: A new request starts only when the queue held at most 4 bytes (at least 2 free slots) in the cycle before `mem_req_o` rises. The queue level never exceeds 6.
- R4: A completed fetch adds two bytes to the queue. The byte from the even (lower) address is popped before the byte from the odd address, and `mem_data_i[7:0]` holds the lower-addressed byte.
- R5: After each completed, non-dropped fetch the offset advances by 2. Successive requests therefore walk up memory in steps of two bytes.
- R6: Once `mem_req_o` is high, it stays high and `mem_addr_o` stays unchanged until a cycle in which `mem_rdy_i` is high.
- R7: In the cycle after `flush_i` is high the queue is empty. The next new request uses the flush target.
- R8: If a request is outstanding when a flush arrives, the word it later returns is not written into the queue.
- R9: A pop while the queue is empty has no effect. `empty_o` stays 1, the level stays 0, and the next byte popped is still the first byte of the stream.
- R10: Fetching runs while the consumer pops on consecutive cycles. A back-to-back pop stream returns bytes in strictly increasing address order with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Taken branch: discard queue, load new target |
| flush_cs_i | input | 16 | Segment of branch target |
| flush_ip_i | input | 16 | Offset of branch target |
| pop_i | input | 1 | Consumer takes the head byte |
| byte_o | output | 8 | Head byte of the queue |
| empty_o | output | 1 | Queue holds no bytes |
| level_o | output | 3 | Number of bytes in the queue |
| mem_req_o | output | 1 | Word fetch request valid |
| mem_addr_o | output | 20 | Physical address of the requested word |
| mem_rdy_i | input | 1 | Memory accepts request; data valid this cycle |
| mem_data_i | input | 16 | Returned word; low byte is the lower address |

## Verification
The assertions assume that memory completes the handshake in the same cycle it raises `mem_rdy_i`, with data valid in that cycle. They also assume that `mem_rdy_i` is low whenever no request is pending. The bench's memory model raises ready only while a request is visible, after a set number of wait cycles, and drops it as soon as the request goes away. Flush targets are chosen so that each stream stays linear in physical space and does not cross an offset rollover, because the expected bytes are computed as consecutive addresses.

// File: rtl/fq_pkg.sv
package fq_pkg;
    localparam int unsigned SEG_W  = 16;
    localparam int unsigned PHYS_W = 20;

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [PHYS_W-1:0] phys_t;

    // segment:offset pair
    typedef struct packed {
        seg_t seg;
        seg_t off;
    } far_ptr_t;

    typedef enum logic [1:0] {
        FQ_IDLE    = 2'd0,  // no request on the port
        FQ_BUSY    = 2'd1,  // request pending, data will be kept
        FQ_DISCARD = 2'd2   // request pending, data will be dropped
    } fetch_st_e;

    function automatic phys_t phys_of(input far_ptr_t p);
        phys_t base;
        base = {p.seg, 4'h0};
        return base + phys_t'(p.off);
    endfunction
endpackage

// File: rtl/fq_byte_queue.sv
module fq_byte_queue #(
    parameter int unsigned DEPTH = 6,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          push_i,
    input  logic [15:0]   push_word_i,
    input  logic          pop_i,
    output logic [7:0]    head_o,
    output logic [LW-1:0] count_o
);
    logic [7:0]    slot_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q, wr_hi;
    logic [LW-1:0] cnt_q, cnt_d;
    logic          pop_ok;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign wr_hi  = step(wr_q);
    assign pop_ok = pop_i && (cnt_q != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (push_i) cnt_d = cnt_d + LW'(2);
        if (pop_ok) cnt_d = cnt_d - LW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= step(wr_hi);
            if (pop_ok) rd_q <= step(rd_q);
            cnt_q <= cnt_d;
        end
    end

    // storage carries no reset; validity is tracked by the count
    always_ff @(posedge clk) begin
        if (push_i && !clear_i) begin
            slot_q[wr_q]  <= push_word_i[7:0];
            slot_q[wr_hi] <= push_word_i[15:8];
        end
    end

    assign head_o  = slot_q[rd_q];
    assign count_o = cnt_q;
endmodule

// File: rtl/fq_fetch_ctrl.sv
module fq_fetch_ctrl
    import fq_pkg::*;
#(
    parameter seg_t RESET_SEG = 16'hFFFF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     flush_i,
    input  far_ptr_t flush_tgt_i,
    input  logic     space_ok_i,
    input  logic     mem_rdy_i,
    output logic     mem_req_o,
    output phys_t    mem_addr_o,
    output logic     push_o
);
    far_ptr_t  pc_q;
    fetch_st_e st_q;
    phys_t     addr_q;

    assign push_o     = (st_q == FQ_BUSY) && mem_rdy_i && !flush_i;
    assign mem_req_o  = (st_q != FQ_IDLE);
    assign mem_addr_o = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '{seg: RESET_SEG, off: '0};
            st_q   <= FQ_IDLE;
            addr_q <= '0;
        end else begin
            if (flush_i)     pc_q     <= flush_tgt_i;
            else if (push_o) pc_q.off <= pc_q.off + seg_t'(2);

            case (st_q)
                FQ_IDLE: begin
                    if (!flush_i && space_ok_i) begin
                        st_q   <= FQ_BUSY;
                        addr_q <= phys_of(pc_q);
                    end
                end
                FQ_BUSY: begin
                    if (mem_rdy_i)    st_q <= FQ_IDLE;
                    else if (flush_i) st_q <= FQ_DISCARD;
                end
                FQ_DISCARD: begin
                    if (mem_rdy_i) st_q <= FQ_IDLE;
                end
                default: st_q <= FQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fetch_queue_unit.sv
module fetch_queue_unit
    import fq_pkg::*;
#(
    parameter int unsigned DEPTH     = 6,
    parameter seg_t        RESET_SEG = 16'hFFFF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush_i,
    input  logic [15:0]                  flush_cs_i,
    input  logic [15:0]                  flush_ip_i,
    input  logic                         pop_i,
    output logic [7:0]                   byte_o,
    output logic                         empty_o,
    output logic [$clog2(DEPTH+1)-1:0]   level_o,
    output logic                         mem_req_o,
    output logic [19:0]                  mem_addr_o,
    input  logic                         mem_rdy_i,
    input  logic [15:0]                  mem_data_i
);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    far_ptr_t      tgt;
    logic          push;
    logic          space_ok;
    logic [LW-1:0] count;

    assign tgt      = '{seg: flush_cs_i, off: flush_ip_i};
    assign space_ok = (count <= LW'(DEPTH - 2));

    fq_fetch_ctrl #(.RESET_SEG(RESET_SEG)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (flush_i),
        .flush_tgt_i (tgt),
        .space_ok_i  (space_ok),
        .mem_rdy_i   (mem_rdy_i),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .push_o      (push)
    );

    fq_byte_queue #(.DEPTH(DEPTH)) u_queue (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (flush_i),
        .push_i      (push),
        .push_word_i (mem_data_i),
        .pop_i       (pop_i && !flush_i),
        .head_o      (byte_o),
        .count_o     (count)
    );

    assign level_o = count;
    assign empty_o = (count == '0);
endmodule

// File: rtl/fq_checker.sv
module fq_checker #(
    parameter int unsigned DEPTH = 6,
    localparam int unsigned LW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          flush_i,
    input logic          pop_i,
    input logic          empty_o,
    input logic [LW-1:0] level_o,
    input logic          mem_req_o,
    input logic [19:0]   mem_addr_o,
    input logic          mem_rdy_i
);
    // R6: request held steady until ready
    a_r6_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R3: capacity never exceeded
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        level_o <= LW'(DEPTH));

    // R3: launch only with two free slots
    a_r3_launch_room: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req_o) |-> ($past(level_o) <= LW'(DEPTH - 2)));

    // R7: flush empties the queue
    a_r7_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> empty_o);

    // R9: popping an empty queue leaves it empty
    a_r9_pop_empty: assert property (@(posedge clk) disable iff (rst)
        (empty_o && pop_i && !(mem_req_o && mem_rdy_i)) |=> empty_o);
endmodule

bind fetch_queue_unit fq_checker #(.DEPTH(DEPTH)) u_fq_checker (
    .clk        (clk),
    .rst        (rst),
    .flush_i    (flush_i),
    .pop_i      (pop_i),
    .empty_o    (empty_o),
    .level_o    (level_o),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_rdy_i  (mem_rdy_i)
);

// File: tb/fetch_queue_unit_bench.sv
`timescale 1ns/1ps
module fetch_queue_unit_bench;
    logic        clk = 1'b0, rst = 1'b1, flush = 1'b0, pop = 1'b0, rdy = 1'b0;
    logic [15:0] fcs = '0, fip = '0, mdata = '0;
    logic [7:0]  byte_o;
    logic        empty_o, req;
    logic [2:0]  level_o;
    logic [19:0] addr;

    int checks = 0, errors = 0, lat = 0, wcnt = 0, cyc = 0;
    logic [19:0] nxt;

    // cs[47:32] ip[31:16] latency[15:8] pops[7:0]
    localparam logic [47:0] VEC [4] = '{
        48'h1234_0010_00_14,
        48'hABCD_00FE_03_0C,
        48'hFFFF_0020_01_0A,   // physical wrap to 00010
        48'h8000_7FF0_05_09
    };

    fetch_queue_unit u_fetch_queue_unit (
        .clk(clk), .rst(rst), .flush_i(flush), .flush_cs_i(fcs), .flush_ip_i(fip),
        .pop_i(pop), .byte_o(byte_o), .empty_o(empty_o), .level_o(level_o),
        .mem_req_o(req), .mem_addr_o(addr), .mem_rdy_i(rdy), .mem_data_i(mdata)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h3C;
    endfunction

    // memory responder
    always @(negedge clk) begin
        if (!req) begin
            rdy  = 1'b0;
            wcnt = 0;
        end else if (!rdy) begin
            if (wcnt >= lat) begin
                rdy   = 1'b1;
                mdata = {mem_byte(addr + 20'd1), mem_byte(addr)};
            end else begin
                wcnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pop_expect(input string tag, input logic [19:0] a);
        while (empty_o) @(negedge clk);
        chk(tag, {24'd0, byte_o}, {24'd0, mem_byte(a)});
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic do_flush(input logic [15:0] cs, input logic [15:0] ip);
        fcs = cs; fip = ip; flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk("R7 empty after flush", {31'd0, empty_o}, 32'd1);
    endtask

    task automatic wait_new_req;
        while (req) @(negedge clk);
        while (!req) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 empty in reset", {31'd0, empty_o}, 32'd1);
        chk("R1 no request in reset", {31'd0, req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first request", {31'd0, req}, 32'd1);
        chk("R1 first address", {12'd0, addr}, 32'hFFFF0);

        // R4/R5/R10 linear stream from reset vector
        nxt = 20'hFFFF0;
        for (int k = 0; k < 8; k++) begin
            pop_expect("R4 reset stream byte", nxt);
            nxt = nxt + 20'd1;
        end

        // R3 fill and two-slot rule
        repeat (30) @(negedge clk);
        chk("R3 full level", {29'd0, level_o}, 32'd6);
        chk("R3 idle when full", {31'd0, req}, 32'd0);
        pop_expect("R4 byte", nxt); nxt = nxt + 20'd1;
        repeat (10) @(negedge clk);
        chk("R3 level five", {29'd0, level_o}, 32'd5);
        chk("R3 no fetch with one free", {31'd0, req}, 32'd0);
        pop_expect("R4 byte", nxt); nxt = nxt + 20'd1;
        @(negedge clk);
        chk("R3 fetch with two free", {31'd0, req}, 32'd1);
        chk("R5 offset advanced by two per word", {12'd0, addr}, 32'hFFFFE);

        // vector table: flush targets, latencies, pop bursts
        for (int i = 0; i < 4; i++) begin
            lat = int'(VEC[i][15:8]);
            do_flush(VEC[i][47:32], VEC[i][31:16]);
            nxt = {VEC[i][47:32], 4'h0} + {4'h0, VEC[i][31:16]};
            wait_new_req();
            chk("R2 target address", {12'd0, addr}, {12'd0, nxt});
            for (int k = 0; k < int'(VEC[i][7:0]); k++) begin
                pop_expect("R10 streamed byte", nxt);
                nxt = nxt + 20'd1;
            end
        end

        // R8/R9/R6 flush during outstanding request
        lat = 8;
        do_flush(16'h2000, 16'h0000);
        wait_new_req();
        chk("R2 address A", {12'd0, addr}, 32'h20000);
        do_flush(16'h3000, 16'h0040);
        chk("R9 empty before pop", {31'd0, empty_o}, 32'd1);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        chk("R9 level after empty pop", {29'd0, level_o}, 32'd0);
        while (req) @(negedge clk);
        chk("R8 stale word dropped", {29'd0, level_o}, 32'd0);
        while (!req) @(negedge clk);
        chk("R7 new target address", {12'd0, addr}, 32'h30040);
        repeat (4) @(negedge clk);
        chk("R6 request held", {11'd0, req, addr}, {11'd0, 1'b1, 20'h30040});
        nxt = 20'h30040;
        for (int k = 0; k < 4; k++) begin
            pop_expect("R8 byte from new target", nxt);
            nxt = nxt + 20'd1;
        end

        // R1 reset mid-stream
        lat = 0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 empty in reset again", {31'd0, empty_o}, 32'd1);
        chk("R1 no request in reset again", {31'd0, req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 restart address", {12'd0, addr}, 32'hFFFF0);
        pop_expect("R1 first byte after reset", 20'hFFFF0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule